// File: doc/BRIEF.md
# Processor status code encoder

This block turns execution-pipeline events into a 4-bit status code, one code per clock. The code is registered and changes only on the rising clock edge. It tracks the operand execution pipeline and has nothing to do with external bus traffic. A trace probe reads the code stream and follows instruction execution cycle by cycle.

Each cycle the pipeline reports four things: whether an instruction begins, whether the current instruction continues into another cycle, whether the beginning instruction is a trigger-pulse or debug-write kind, and whether it switches the core into user mode. The user-mode switch is not reported while the causing instruction executes. One report cycle is inserted right after that instruction completes. An instruction that begins in the inserted cycle is refused with a stall, and the pipeline presents it again in the next cycle.

Top module: `pst_encoder`

## Requirements
- R1: The asynchronous active-low reset drives `code_o` to 0x0 and drops any pending user-mode report. After reset, code 0x3 appears only after a new user-mode instruction has started.
- R2: An accepted start with `trig_i` low gives code 0x1 on the cycle after the start is presented.
- R3: An accepted start with `trig_i` high gives code 0x4 instead of 0x1.
- R4: Continuation alone (`cont_i` high, `start_i` low, no report due) gives code 0x0 on the next cycle.
- R5: When `start_i` and `cont_i` are both high, the start wins and the code is 0x1 or 0x4.
- R6: With no event and no report due, the code is 0x0.
- R7: A start accepted with `user_i` high marks a report as pending. The instruction completes in the first later cycle where `cont_i` is low or `start_i` is high. The next cycle shows code 0x3. A single-cycle instruction therefore gives the sequence 0x1, 0x3.
- R8: While a report is pending, the continuation cycles of the causing instruction give 0x0. The 0x3 follows only after the last of them.
- R9: `stall_o` is high, combinationally, in the completion cycle of a pending report only if `start_i` is high in that cycle. That start is not encoded. Presented again in the next cycle, it gives its normal code.
- R10: Each user-mode instruction gives exactly one 0x3. A 0x3 is never followed directly by another 0x3.
- R11: `user_i` has no effect unless `start_i` is high and accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Status clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | First execution cycle of an instruction |
| cont_i | input | 1 | Additional cycle of a multi-cycle instruction |
| trig_i | input | 1 | Starting instruction is a trigger-pulse or debug-write instruction |
| user_i | input | 1 | Starting instruction enters user mode |
| code_o | output | 4 | Registered status code |
| stall_o | output | 1 | Start refused this cycle; present it again next cycle |

## Verification
The bench targets when the deferred report appears. Each of the following is checked:
- A design that reports too early would put 0x3 in place of the 0x1 of the causing instruction, or in the middle of its continuation cycles.
- A design that forgets to clear the pending flag would emit 0x3 twice.
- A design that does not refuse a start colliding with the report would either lose the 0x3 or encode the start one cycle early without raising `stall_o`.
- A design that ignores the start-over-continuation priority would show 0x0 where 0x1 belongs.
- A design whose reset does not drop a pending report would show 0x3 just after reset.

A stray `user_i` pulse without a start is also checked, to make sure it creates no report.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int unsigned CodeW = 4;

  typedef enum logic [CodeW-1:0] {
    PST_CONT  = 4'h0,
    PST_BEGIN = 4'h1,
    PST_USER  = 4'h3,
    PST_TRIG  = 4'h4
  } pst_code_e;
endpackage

// File: rtl/pst_user_defer.sv
module pst_user_defer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cont_i,
  input  logic user_i,
  output logic report_o,
  output logic stall_o,
  output logic pend_o
);
  logic pend_q;
  logic accept;

  // current instruction is done once no continuation follows or a new start arrives
  assign report_o = pend_q & (start_i | ~cont_i);
  assign stall_o  = report_o & start_i;
  assign accept   = start_i & ~stall_o;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (report_o)           pend_q <= 1'b0;
    else if (accept && user_i)   pend_q <= 1'b1;
  end

  // R10: a report always clears the pending flag
  a_r10_clear_after_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |=> !pend_q);
  // R11: user_i alone never arms a report
  a_r11_user_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !start_i) |=> !pend_q);
endmodule

// File: rtl/pst_code_arb.sv
module pst_code_arb
  import pst_pkg::*;
(
  input  logic      report_i,
  input  logic      start_i,
  input  logic      trig_i,
  output pst_code_e code_o
);
  // report beats start, start beats continuation; idle and continuation share 0x0
  always_comb begin
    if (report_i)     code_o = PST_USER;
    else if (start_i) code_o = trig_i ? PST_TRIG : PST_BEGIN;
    else              code_o = PST_CONT;
  end
endmodule

// File: rtl/pst_encoder.sv
module pst_encoder
  import pst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             trig_i,
  input  logic             user_i,
  output logic [CodeW-1:0] code_o,
  output logic             stall_o
);
  logic      report;
  logic      pend;
  pst_code_e code_d;
  logic [CodeW-1:0] code_q;

  pst_user_defer i_defer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cont_i   (cont_i),
    .user_i   (user_i),
    .report_o (report),
    .stall_o  (stall_o),
    .pend_o   (pend)
  );

  pst_code_arb i_arb (
    .report_i (report),
    .start_i  (start_i),
    .trig_i   (trig_i),
    .code_o   (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= PST_CONT;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  a_r2_begin_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stall_o && !trig_i) |=> code_o == 4'h1);
  a_r3_trig_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stall_o && trig_i) |=> code_o == 4'h4);
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !pend) |=> code_o == 4'h0);
  a_r9_stall_reports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> code_o == 4'h3);
  a_r10_single_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == 4'h3) |=> code_o != 4'h3);
endmodule

// File: tb/test_pst_encoder.sv
module test_pst_encoder;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, cont_i = 1'b0, trig_i = 1'b0, user_i = 1'b0;
  logic [3:0] code_o;
  logic stall_o;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  pst_encoder i_pst_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cont_i(cont_i),
    .trig_i(trig_i), .user_i(user_i), .code_o(code_o), .stall_o(stall_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply inputs at negedge, optionally check stall, then check code after the edge
  task automatic cyc(input logic s, input logic c, input logic t, input logic u,
                     input int exp_code, input int exp_stall, input string req);
    @(negedge clk_i);
    start_i = s; cont_i = c; trig_i = t; user_i = u;
    #1;
    if (exp_stall >= 0) chk({req, " stall"}, int'(stall_o), exp_stall);
    @(posedge clk_i);
    #1;
    chk(req, int'(code_o), exp_code);
  endtask

  task automatic t_reset;
    #1 chk("R1 reset code", int'(code_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic t_basic;
    cyc(1, 0, 0, 0, 1, 0, "R2 begin");
    cyc(1, 0, 1, 0, 4, 0, "R3 trig");
    cyc(0, 1, 0, 0, 0, 0, "R4 cont");
    cyc(1, 1, 0, 0, 1, 0, "R5 start over cont");
    cyc(1, 1, 1, 0, 4, 0, "R5 trig over cont");
    cyc(0, 0, 0, 0, 0, 0, "R6 idle");
  endtask

  task automatic t_user_single;
    cyc(1, 0, 0, 1, 1, 0, "R7 causing begin");
    cyc(0, 0, 0, 0, 3, 0, "R7 report");
    cyc(0, 0, 0, 0, 0, 0, "R10 no repeat");
  endtask

  task automatic t_user_multi;
    cyc(1, 0, 1, 1, 4, 0, "R8 causing trig");
    cyc(0, 1, 0, 0, 0, 0, "R8 cont 1");
    cyc(0, 1, 0, 0, 0, 0, "R8 cont 2");
    cyc(0, 0, 0, 0, 3, 0, "R8 report after last cont");
    cyc(0, 0, 0, 0, 0, 0, "R10 idle after report");
  endtask

  task automatic t_collision;
    cyc(1, 0, 0, 1, 1, 0, "R9 causing begin");
    cyc(1, 0, 1, 0, 3, 1, "R9 refused start");
    cyc(1, 0, 1, 0, 4, 0, "R9 start replayed");
    cyc(0, 0, 0, 0, 0, 0, "R10 single report");
  endtask

  task automatic t_stray_user;
    cyc(0, 0, 0, 1, 0, 0, "R11 stray user");
    cyc(0, 0, 0, 0, 0, 0, "R11 no report");
    cyc(0, 1, 0, 1, 0, 0, "R11 user with cont");
    cyc(0, 0, 0, 0, 0, 0, "R11 still no report");
  endtask

  task automatic t_reset_pending;
    cyc(1, 0, 0, 1, 1, 0, "R1 arm");
    @(negedge clk_i);
    start_i = 0; cont_i = 0; user_i = 0; trig_i = 0;
    rst_ni = 1'b0;
    #1 chk("R1 code in reset", int'(code_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R1 pending dropped");
    cyc(0, 0, 0, 0, 0, 0, "R1 still idle");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_user_single();
    t_user_multi();
    t_collision();
    t_stray_user();
    t_reset_pending();
    finish_run();
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule